// File: doc/BRIEF.md
# TDM Frame Sync Generator and Checker

This block keeps frame timing for a PCM/TDM serial link. It does this by counting bit-clock edges. A separate front end turns the bit clock into a one-cycle strobe `bclk_edge` for every bit-clock edge, rising or falling, and also supplies the level `bclk_lvl` that the line has just taken. Each strobe moves a half-bit-clock position counter forward by one. The counter runs over a frame of 8-bit timeslots, with an optional framing bit placed first.

In generate mode the block starts the frame on the first bit-start edge after it is enabled. It then drives a frame sync pulse of programmable width at a programmable distance before bit 0 of timeslot 0.

In receive mode the block waits for the first received sync leading edge that falls on the right kind of bit-clock edge, and takes its timing from that pulse. After that it checks every frame. A leading edge anywhere else raises an extra-sync strobe, and an absent sync at the expected position raises a missing-sync strobe. A status flag reports whether the last complete frame was clean.

Both modes read the same configuration inputs.

Top module: `tdm_frame_sync`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `frame_good`, `frame_start`, `err_extra`, `err_missing`, `slot_idx`, `bit_idx` and `frame_bit` are 0, and `fsync_out` sits at its idle level, which is `cfg_fs_low`.
- R2: A frame spans (8·`cfg_slots` + `cfg_xbit`) bit times. `frame_start` pulses for one clock each time the half-bit position returns to 0. In generate mode the first pulse comes on the first bit-start edge after enable.
- R3: `cfg_bitlen` sets the bit time: 0 gives 1 bit clock, 1 gives 2 bit clocks and 2 gives 4 bit clocks. Each bit time therefore holds 2<<`cfg_bitlen` half positions. Code 3, or `cfg_slots` = 0, is illegal and keeps the block idle as in R1.
- R4: An edge is a bit-start edge when `bclk_lvl` XOR `cfg_bclk_fall` is 1. With `cfg_bclk_fall` = 0 that is the rising edge; with 1 it is the falling edge.
- R5: In generate mode the sync leading edge sits at half position S = (P0 − `cfg_fs_loc`) mod frame length. P0 is one bit time in half positions when `cfg_xbit` = 1, and 0 otherwise, so the framing bit delays the sync by one bit time. The sync stays asserted for `cfg_fs_len` half positions. The asserted level is the inverse of `cfg_fs_low`. Each change appears one clock after the edge strobe.
- R6: `frame_bit` is 1 during the framing bit. Outside it, `slot_idx` and `bit_idx` give the timeslot and the bit number of the current bit time, counted from bit 0 of slot 0.
- R7: In receive mode `fsync_in` is sampled `cfg_samp_dly` + 1 clocks after each edge strobe. `cfg_samp_dly` + 1 must be less than the edge spacing.
- R8: In receive mode the first sampled leading edge marks position S, and only if it arrives on a bit-start edge when S is even, or on a mid-bit edge when S is odd. No error strobe is raised before that alignment.
- R9: Once aligned, a sampled leading edge at a position other than S raises `err_extra` for one clock, one clock after the sample.
- R10: Once aligned, no leading edge at position S raises `err_missing` for one clock, one clock after the sample.
- R11: At each sample of position S, `frame_good` takes 1 if the window just closed began with a sync at S and held no extra sync. Otherwise it takes 0.
- R12: In receive mode a sync is asserted when `fsync_in` XOR `cfg_fs_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 0 holds the block idle, 1 runs it |
| gen_mode | input | 1 | 1 generates the sync, 0 checks the received sync |
| bclk_edge | input | 1 | One-clock strobe for every bit-clock edge |
| bclk_lvl | input | 1 | Bit-clock level after the strobed edge |
| fsync_in | input | 1 | Received frame sync |
| cfg_slots | input | SLOT_W | Number of 8-bit timeslots per frame |
| cfg_xbit | input | 1 | Adds one framing bit per frame |
| cfg_bitlen | input | 2 | Bit-time length code |
| cfg_bclk_fall | input | 1 | Falling edge starts a bit time |
| cfg_fs_low | input | 1 | Sync idles high and asserts low |
| cfg_fs_loc | input | LOC_W | Sync lead, in half bit clocks, before slot 0 bit 0 |
| cfg_fs_len | input | LOC_W | Generated sync width, in half bit clocks |
| cfg_samp_dly | input | DLY_W | Extra clocks from an edge to the sync sample |
| fsync_out | output | 1 | Generated frame sync |
| frame_start | output | 1 | One-clock strobe at half position 0 |
| slot_idx | output | SLOT_W | Current timeslot |
| bit_idx | output | 3 | Current bit within the slot |
| frame_bit | output | 1 | Framing bit in progress |
| frame_good | output | 1 | Last complete frame had one correctly placed sync |
| err_extra | output | 1 | Misplaced sync strobe |
| err_missing | output | 1 | Absent sync strobe |

## Verification
The position-driven outputs are due one clock after an edge strobe: `frame_start`, `fsync_out`, `slot_idx`, `bit_idx` and `frame_bit` all follow the position register. The receive results come later. The sample is taken `cfg_samp_dly` + 1 clocks after the strobe, and `err_extra`, `err_missing` and `frame_good` change on the clock after that sample. The bench's reference model advances on the same rising edge as the design, using this latency arithmetic. Every output is compared with the model on each falling edge, so each result is checked in the exact cycle it is due, and a result that arrives early or late shows up as a mismatch.

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync #(
  parameter int SLOT_W = 10,
  parameter int LOC_W  = 5,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              gen_mode,
  input  logic              bclk_edge,
  input  logic              bclk_lvl,
  input  logic              fsync_in,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_xbit,
  input  logic [1:0]        cfg_bitlen,
  input  logic              cfg_bclk_fall,
  input  logic              cfg_fs_low,
  input  logic [LOC_W-1:0]  cfg_fs_loc,
  input  logic [LOC_W-1:0]  cfg_fs_len,
  input  logic [DLY_W-1:0]  cfg_samp_dly,
  output logic              fsync_out,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [2:0]        bit_idx,
  output logic              frame_bit,
  output logic              frame_good,
  output logic              err_extra,
  output logic              err_missing
);

  localparam int POS_W = SLOT_W + 7;
  localparam int BIT_W = SLOT_W + 4;

  logic              active;
  logic [2:0]        half_shift;
  logic [BIT_W-1:0]  bits_per_frame;
  logic [POS_W-1:0]  frame_len, half_per_bit, first_bit, loc_ext, sync_pos;
  logic [POS_W-1:0]  pos, pos_inc;
  logic              run, pend, last_start, prev_act, win_ok;
  logic [LOC_W-1:0]  lc;
  logic [DLY_W-1:0]  dcnt;
  logic              start_edge, samp, rx_act, lead, parity_ok;
  logic [BIT_W-1:0]  bt;
  logic [SLOT_W+2:0] bit_num;
  logic              in_fbit;

  assign active         = enable && (cfg_bitlen != 2'd3) && (cfg_slots != '0);
  assign half_shift     = {1'b0, cfg_bitlen} + 3'd1;
  assign bits_per_frame = {1'b0, cfg_slots, 3'b000} + BIT_W'(cfg_xbit);
  assign frame_len      = POS_W'(bits_per_frame) << half_shift;
  assign half_per_bit   = POS_W'(2) << cfg_bitlen;
  assign first_bit      = cfg_xbit ? half_per_bit : '0;
  assign loc_ext        = POS_W'(cfg_fs_loc);
  assign sync_pos       = (first_bit >= loc_ext) ? first_bit - loc_ext
                                                 : first_bit + frame_len - loc_ext;
  assign pos_inc        = (pos == frame_len - POS_W'(1)) ? '0 : pos + POS_W'(1);

  assign start_edge = bclk_lvl ^ cfg_bclk_fall;
  assign samp       = pend && (dcnt == '0) && !bclk_edge && !gen_mode;
  assign rx_act     = fsync_in ^ cfg_fs_low;
  assign lead       = rx_act && !prev_act;
  assign parity_ok  = last_start == !sync_pos[0];

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      run         <= 1'b0;
      pos         <= '0;
      lc          <= '0;
      pend        <= 1'b0;
      dcnt        <= '0;
      last_start  <= 1'b0;
      prev_act    <= 1'b0;
      win_ok      <= 1'b0;
      frame_good  <= 1'b0;
      frame_start <= 1'b0;
      err_extra   <= 1'b0;
      err_missing <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      err_extra   <= 1'b0;
      err_missing <= 1'b0;
      if (bclk_edge) begin
        last_start <= start_edge;
        pend       <= 1'b1;
        dcnt       <= cfg_samp_dly;
        if (gen_mode && !run) begin
          if (start_edge) begin
            run         <= 1'b1;
            pos         <= '0;
            frame_start <= 1'b1;
            lc          <= (sync_pos == '0) ? cfg_fs_len : '0;
          end
        end else if (run) begin
          pos         <= pos_inc;
          frame_start <= (pos_inc == '0);
          if (gen_mode)
            lc <= (pos_inc == sync_pos) ? cfg_fs_len
                                        : ((lc != '0) ? lc - LOC_W'(1) : '0);
        end
      end else if (pend) begin
        if (dcnt == '0) pend <= 1'b0;
        else            dcnt <= dcnt - DLY_W'(1);
      end
      if (samp) begin
        prev_act <= rx_act;
        if (!run) begin
          if (lead && parity_ok) begin
            run         <= 1'b1;
            pos         <= sync_pos;
            win_ok      <= 1'b1;
            frame_start <= (sync_pos == '0);
          end
        end else if (pos == sync_pos) begin
          frame_good  <= win_ok;
          win_ok      <= lead;
          err_missing <= !lead;
        end else if (lead) begin
          err_extra <= 1'b1;
          win_ok    <= 1'b0;
        end
      end
    end
  end

  assign fsync_out = cfg_fs_low ^ (gen_mode && run && (lc != '0));

  assign bt       = BIT_W'(pos >> half_shift);
  assign in_fbit  = cfg_xbit && (bt == '0);
  assign bit_num  = (SLOT_W+3)'(bt - BIT_W'(cfg_xbit));
  assign slot_idx = (run && !in_fbit) ? bit_num[SLOT_W+2:3] : '0;
  assign bit_idx  = (run && !in_fbit) ? bit_num[2:0] : 3'd0;
  assign frame_bit = run && in_fbit;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!frame_good && !frame_start && !err_extra && !err_missing));

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active) |-> (pos < frame_len));

  assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gen_mode && !bclk_edge) |=> $stable(lc));

  assert_fstart_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_idx == '0 && bit_idx == 3'd0));

  assert_no_err_unaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!err_extra && !err_missing));

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_extra |=> !err_extra);

  assert_miss_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_missing |=> !err_missing);

endmodule

// File: tb/test_tdm_frame_sync.sv
module test_tdm_frame_sync;
  localparam int SW = 10;
  localparam int LW = 5;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, gen_mode = 1'b0;
  logic bclk_edge = 1'b0, bclk_lvl = 1'b0, fsync_in = 1'b0;
  logic [SW-1:0] cfg_slots = SW'(2);
  logic cfg_xbit = 1'b0, cfg_bclk_fall = 1'b0, cfg_fs_low = 1'b0;
  logic [1:0] cfg_bitlen = 2'd0;
  logic [LW-1:0] cfg_fs_loc = LW'(2), cfg_fs_len = LW'(3);
  logic [DW-1:0] cfg_samp_dly = '0;
  logic fsync_out, frame_start, frame_bit, frame_good, err_extra, err_missing;
  logic [SW-1:0] slot_idx;
  logic [2:0] bit_idx;

  always #5 clk = ~clk;

  tdm_frame_sync #(.SLOT_W(SW), .LOC_W(LW), .DLY_W(DW)) i_tdm_frame_sync (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gen_mode(gen_mode),
    .bclk_edge(bclk_edge), .bclk_lvl(bclk_lvl), .fsync_in(fsync_in),
    .cfg_slots(cfg_slots), .cfg_xbit(cfg_xbit), .cfg_bitlen(cfg_bitlen),
    .cfg_bclk_fall(cfg_bclk_fall), .cfg_fs_low(cfg_fs_low), .cfg_fs_loc(cfg_fs_loc),
    .cfg_fs_len(cfg_fs_len), .cfg_samp_dly(cfg_samp_dly),
    .fsync_out(fsync_out), .frame_start(frame_start), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .frame_bit(frame_bit), .frame_good(frame_good),
    .err_extra(err_extra), .err_missing(err_missing));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int hp = 4, phase = 0, ecount = -1, rlen = 2, miss_k = -1, xtra_e = -1;
  bit rx_on = 1'b0;
  int dut_fst = 0, mdl_fst = 0, dut_ex = 0, dut_ms = 0;

  int cyc = 0, m_pos = 0, m_due = -1;
  bit m_run = 0, m_started = 0, m_last = 0, m_prev = 0, m_win = 0;
  bit e_good = 0, e_ex = 0, e_ms = 0, e_fst = 0;

  function automatic int f_flen();
    return (int'(cfg_slots) * 8 + int'(cfg_xbit)) * (2 << cfg_bitlen);
  endfunction

  function automatic int f_spos();
    int p0;
    p0 = cfg_xbit ? (2 << cfg_bitlen) : 0;
    return (p0 >= int'(cfg_fs_loc)) ? p0 - int'(cfg_fs_loc) : p0 + f_flen() - int'(cfg_fs_loc);
  endfunction

  function automatic bit remote_act(int e);
    int fl, sp, d;
    fl = f_flen();
    sp = f_spos();
    if (e == xtra_e) return 1'b1;
    if (e < sp) return 1'b0;
    d = ((e % fl) - sp + fl) % fl;
    if (d >= rlen) return 1'b0;
    if ((e - d - sp) / fl == miss_k) return 1'b0;
    return 1'b1;
  endfunction

  // behavioural reference, advanced on the same edge as the design
  always @(posedge clk) begin
    bit act, lead;
    int fl, sp;
    cyc++;
    fl = f_flen();
    sp = f_spos();
    if (!rst_n || !enable || cfg_bitlen == 2'd3 || cfg_slots == '0) begin
      m_run = 0; m_pos = 0; m_started = 0; m_due = -1; m_last = 0; m_prev = 0;
      m_win = 0; e_good = 0; e_ex = 0; e_ms = 0; e_fst = 0;
    end else begin
      e_ex = 0; e_ms = 0; e_fst = 0;
      if (bclk_edge) begin
        m_last = bclk_lvl ^ cfg_bclk_fall;
        m_due = cyc + int'(cfg_samp_dly) + 1;
        if (gen_mode && !m_run) begin
          if (m_last) begin
            m_run = 1; m_pos = 0; e_fst = 1;
            if (sp == 0) m_started = 1;
          end
        end else if (m_run) begin
          m_pos = (m_pos + 1) % fl;
          e_fst = (m_pos == 0);
          if (gen_mode && m_pos == sp) m_started = 1;
        end
      end else if (!gen_mode && cyc == m_due) begin
        act = fsync_in ^ cfg_fs_low;
        lead = act && !m_prev;
        m_prev = act;
        if (!m_run) begin
          if (lead && (m_last == (sp % 2 == 0))) begin
            m_run = 1; m_pos = sp; m_win = 1; e_fst = (sp == 0);
          end
        end else if (m_pos == sp) begin
          e_good = m_win; m_win = lead; e_ms = !lead;
        end else if (lead) begin
          e_ex = 1; m_win = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int fl, sp, bt, d, es, eb, efb;
    bit efs, fb;
    fl = f_flen();
    sp = f_spos();
    efs = cfg_fs_low ^ (gen_mode && m_run && m_started &&
                        (((m_pos - sp + fl) % fl) < int'(cfg_fs_len)));
    es = 0; eb = 0; efb = 0;
    if (m_run) begin
      bt = m_pos / (2 << cfg_bitlen);
      fb = cfg_xbit && bt == 0;
      d = bt - int'(cfg_xbit);
      efb = int'(fb);
      if (!fb) begin es = d / 8; eb = d % 8; end
    end
    chk("R5 fsync_out", int'(fsync_out), int'(efs));
    chk("R2 frame_start", int'(frame_start), int'(e_fst));
    chk("R6 slot_idx", int'(slot_idx), es);
    chk("R6 bit_idx", int'(bit_idx), eb);
    chk("R6 frame_bit", int'(frame_bit), efb);
    chk("R11 frame_good", int'(frame_good), int'(e_good));
    chk("R9 err_extra", int'(err_extra), int'(e_ex));
    chk("R10 err_missing", int'(err_missing), int'(e_ms));
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      compare_all();
      dut_fst += int'(frame_start);
      mdl_fst += int'(e_fst);
      dut_ex += int'(err_extra);
      dut_ms += int'(err_missing);
    end
    bclk_edge = 1'b0;
    if (enable) begin
      phase++;
      if (phase == hp) begin
        phase = 0;
        bclk_edge = 1'b1;
        bclk_lvl = ~bclk_lvl;
        ecount++;
      end
    end
    fsync_in = cfg_fs_low ^ (rx_on && ecount >= 0 && remote_act(ecount));
  endtask

  task automatic setup(input bit gen, input int slots, input bit xb, input int bl,
                       input bit fall, input bit low, input int loc, input int len,
                       input int dly, input int h, input bit rx, input int mk, input int xe);
    enable = 1'b0;
    repeat (3) tick();
    gen_mode = gen; cfg_slots = SW'(slots); cfg_xbit = xb; cfg_bitlen = 2'(bl);
    cfg_bclk_fall = fall; cfg_fs_low = low; cfg_fs_loc = LW'(loc); cfg_fs_len = LW'(len);
    cfg_samp_dly = DW'(dly); hp = h; rx_on = rx; miss_k = mk; xtra_e = xe;
    bclk_lvl = fall;
    phase = 0; ecount = -1;
    tick();
    tick();
    enable = 1'b1;
    dut_fst = 0; mdl_fst = 0; dut_ex = 0; dut_ms = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset frame_good", int'(frame_good), 0);
    chk("R1 reset fsync idle", int'(fsync_out), 0);
    chk("R1 reset frame_start", int'(frame_start), 0);
    rst_n = 1'b1;
    repeat (2) tick();

    setup(1, 2, 0, 0, 0, 0, 2, 3, 0, 4, 0, -1, -1);
    repeat (500) tick();
    chk("R2 frame count", dut_fst, mdl_fst);
    chk("R2 frames seen", int'(dut_fst > 2), 1);

    setup(1, 3, 1, 1, 1, 1, 3, 5, 0, 3, 0, -1, -1);
    repeat (800) tick();
    chk("R4 falling-edge frames", int'(dut_fst > 1), 1);

    setup(1, 2, 0, 3, 0, 0, 2, 3, 0, 4, 0, -1, -1);
    repeat (200) tick();
    chk("R3 illegal bit length gives no frames", dut_fst, 0);
    chk("R3 illegal bit length sync idle", int'(fsync_out), 0);

    setup(0, 2, 0, 0, 0, 0, 2, 3, 2, 6, 1, -1, -1);
    repeat (1200) tick();
    chk("R8 clean stream raises no strobes", dut_ex + dut_ms, 0);
    chk("R7 delayed sample gives good frame", int'(frame_good), 1);

    setup(0, 2, 0, 0, 0, 0, 2, 3, 4, 6, 1, 3, 5 * 32 + 10);
    repeat (1800) tick();
    chk("R9 extra sync reported", int'(dut_ex > 0), 1);
    chk("R10 missing sync reported", int'(dut_ms > 0), 1);
    chk("R11 recovered after faults", int'(frame_good), 1);

    setup(0, 1, 1, 2, 1, 1, 5, 3, 0, 4, 1, -1, -1);
    repeat (1600) tick();
    chk("R12 inverted sync polarity good", int'(frame_good), 1);
    chk("R12 no strobes", dut_ex + dut_ms, 0);

    enable = 1'b0;
    repeat (3) tick();
    chk("R1 disabled frame_good", int'(frame_good), 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule